// File: doc/BRIEF.md
# BCD Wall-Clock Time and Calendar Counter

This block keeps the time of day and the calendar date. It advances once for each one-cycle pulse on a one-second enable input. Software sets and reads it through a single-cycle register write port and a combinational read port, both with 32-bit data. Time and date are presented as packed BCD words. Hours are shown on either a 24-hour scale or a 12-hour scale with a PM flag. A weekday counter, a leap-year flag and one-hour daylight-saving steps complete the function.

After reset the counter is locked. It holds its reset values, ignores the one-second pulse and ignores every register write except to the key register. It unlocks for good once the key 0xA5EB1357 is written. Internally the seconds, minutes, hours, day, month and year are kept as binary values. They are encoded to BCD only at the output and decoded from BCD on a write. Because of this, a change of hour scale changes only how the stored time is shown.

Register map (word address): 0 key/status, 1 time, 2 date, 3 weekday, 4 hour format, 5 leap flag (read-only), 6 daylight-saving control; address 7 reads 0.

Top module: `rtc_bcd_clock`

## Requirements
- R1: After reset, and for as long as the block is locked, it holds these values: status bit 0 reads 0, time word 0x000000, date word 0x000101, weekday 6 and the 24-hour format. While locked, one-second pulses and writes to addresses 1 to 6 have no effect.
- R2: Writing 0xA5EB1357 to address 0 sets the active status, and the status then stays set. Any other value written there leaves the block locked. A read of address 0 returns only the status in bit 0, with all other bits 0.
- R3: The time word holds seconds units in [3:0], seconds tens in [6:4], minutes units in [11:8], minutes tens in [14:12], hours units in [19:16] and hours tens in [21:20]. In 24-hour mode each pulse adds one second, and 23:59:59 rolls to 00:00:00 with a carry into the date.
- R4: The date word holds day units in [3:0], day tens in [5:4], month units in [11:8], month tens in bit 12, year units in [19:16] and year tens in [23:20]. Months have their fixed lengths, December rolls to January, and year 99 rolls to 00.
- R5: A year is a leap year when it is divisible by 4 (00 included). In a leap year February has 29 days, otherwise 28. leap_o and bit 0 of address 5 show the flag for the current year.
- R6: Bit 0 of address 4 selects the hour scale: 1 is 24-hour and 0 is 12-hour. On the 12-hour scale hours run 12, 1, …, 11, bit 21 is PM and bit 20 is the hours tens digit. PM toggles on the 11→12 step, and 11:59:59 PM rolls to 12:00:00 AM with a date carry. Changing the scale re-encodes the same instant.
- R7: The weekday runs 0 (Sunday) to 6 (Saturday) and steps with every date carry or borrow, wrapping 6→0 and 0→6. A write of the reserved value 7 is ignored.
- R8: A write to address 6 with bit 0 set and bit 1 clear adds one hour, carrying into date and weekday. It also sets the record bit (bit 2). Bits 0 and 1 always read 0.
- R9: A write to address 6 with bit 1 set and bit 0 clear subtracts one hour, borrowing from date and weekday, and clears the record bit. With both bits set nothing changes. With both clear, bit 2 is written into the record bit.
- R10: A write to address 1, 2, 3 or 6 discards a one-second pulse in the same cycle, so the written value is not advanced.
- R11: The read port returns the current word of the addressed register in the same cycle, and address 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_tick_i | input | 1 | One-cycle pulse per elapsed second |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write word address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read word address |
| rd_data_o | output | 32 | Register read data |
| time_o | output | 32 | Current time word (BCD) |
| date_o | output | 32 | Current date word (BCD) |
| weekday_o | output | 3 | Current weekday |
| leap_o | output | 1 | Current year is a leap year |

## Verification
The assertions check on every cycle that the lock holds the reset values, that the active status never falls, that the weekday never shows 7, that the leap flag agrees with the BCD year digits, that a second step adds one to the units digit, that a time write freezes the date, and how the daylight record bit responds to add and subtract. Month lengths, the year wrap, the 12-hour sequence and its midnight carry, borrows from daylight subtraction across month and year ends, and the re-encoding on a format change can only be shown by the bench's directed scenarios with known expected words.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [ADDR_W-1:0] {
    REG_KEY  = 3'd0,
    REG_TIME = 3'd1,
    REG_DATE = 3'd2,
    REG_WDAY = 3'd3,
    REG_FMT  = 3'd4,
    REG_LEAP = 3'd5,
    REG_DST  = 3'd6
  } reg_idx_e;

  function automatic logic [7:0] bin2bcd(input logic [6:0] v);
    logic [6:0] t, u;
    t = v / 7'd10;
    u = v % 7'd10;
    return {t[3:0], u[3:0]};
  endfunction

  function automatic logic [6:0] bcd2bin(input logic [7:0] b);
    return ({3'b0, b[7:4]} * 7'd10) + {3'b0, b[3:0]};
  endfunction

  function automatic logic [4:0] month_days(input logic [3:0] m, input logic leap);
    case (m)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_unlock.sv
module rtc_unlock #(
  parameter logic [31:0] KEY = 32'hA5EB1357
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        key_wr_i,
  input  logic [31:0] key_i,
  output logic        active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        active_o <= 1'b0;
    else if (key_wr_i && key_i == KEY)  active_o <= 1'b1;
  end
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       ld_i,
  input  logic [5:0] ld_sec_i,
  input  logic [5:0] ld_min_i,
  input  logic [4:0] ld_hr_i,
  input  logic       tick_i,
  input  logic       add_i,
  input  logic       sub_i,
  output logic [5:0] sec_o,
  output logic [5:0] min_o,
  output logic [4:0] hr_o,
  output logic       day_inc_o,
  output logic       day_dec_o
);
  logic wrap_s, wrap_m, wrap_h, step;

  assign wrap_s = sec_o >= 6'd59;
  assign wrap_m = min_o >= 6'd59;
  assign wrap_h = hr_o  >= 5'd23;
  assign step   = tick_i & ~add_i & ~sub_i;

  assign day_inc_o = ~clr_i & ~ld_i & ((add_i & wrap_h) | (step & wrap_s & wrap_m & wrap_h));
  assign day_dec_o = ~clr_i & ~ld_i & ~add_i & sub_i & (hr_o == 5'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_o <= '0; min_o <= '0; hr_o <= '0;
    end else if (clr_i) begin
      sec_o <= '0; min_o <= '0; hr_o <= '0;
    end else if (ld_i) begin
      sec_o <= ld_sec_i; min_o <= ld_min_i; hr_o <= ld_hr_i;
    end else if (add_i) begin
      hr_o <= wrap_h ? 5'd0 : hr_o + 5'd1;
    end else if (sub_i) begin
      hr_o <= (hr_o == 5'd0) ? 5'd23 : hr_o - 5'd1;
    end else if (tick_i) begin
      sec_o <= wrap_s ? 6'd0 : sec_o + 6'd1;
      if (wrap_s) begin
        min_o <= wrap_m ? 6'd0 : min_o + 6'd1;
        if (wrap_m) hr_o <= wrap_h ? 5'd0 : hr_o + 5'd1;
      end
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       ld_date_i,
  input  logic [4:0] ld_day_i,
  input  logic [3:0] ld_mon_i,
  input  logic [6:0] ld_yr_i,
  input  logic       ld_wday_i,
  input  logic [2:0] ld_wval_i,
  input  logic       inc_i,
  input  logic       dec_i,
  output logic [4:0] day_o,
  output logic [3:0] mon_o,
  output logic [6:0] yr_o,
  output logic [2:0] wday_o,
  output logic       leap_o
);
  localparam logic [2:0] WDAY_RST = 3'd6;
  localparam logic [2:0] WDAY_MAX = 3'd6;

  logic [3:0] prev_mon;
  logic [6:0] prev_yr;
  logic [4:0] dim_cur, dim_prev;

  assign leap_o   = (yr_o[1:0] == 2'd0);
  assign prev_mon = (mon_o <= 4'd1) ? 4'd12 : mon_o - 4'd1;
  assign prev_yr  = (mon_o <= 4'd1) ? ((yr_o == 7'd0) ? 7'd99 : yr_o - 7'd1) : yr_o;
  assign dim_cur  = month_days(mon_o, leap_o);
  assign dim_prev = month_days(prev_mon, prev_yr[1:0] == 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      day_o <= 5'd1; mon_o <= 4'd1; yr_o <= '0;
    end else if (clr_i) begin
      day_o <= 5'd1; mon_o <= 4'd1; yr_o <= '0;
    end else if (ld_date_i) begin
      day_o <= ld_day_i; mon_o <= ld_mon_i; yr_o <= ld_yr_i;
    end else if (inc_i) begin
      if (day_o >= dim_cur) begin
        day_o <= 5'd1;
        if (mon_o >= 4'd12) begin
          mon_o <= 4'd1;
          yr_o  <= (yr_o >= 7'd99) ? 7'd0 : yr_o + 7'd1;
        end else begin
          mon_o <= mon_o + 4'd1;
        end
      end else begin
        day_o <= day_o + 5'd1;
      end
    end else if (dec_i) begin
      if (day_o <= 5'd1) begin
        day_o <= dim_prev; mon_o <= prev_mon; yr_o <= prev_yr;
      end else begin
        day_o <= day_o - 5'd1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wday_o <= WDAY_RST;
    else if (clr_i)     wday_o <= WDAY_RST;
    else if (ld_wday_i) wday_o <= ld_wval_i;
    else if (inc_i)     wday_o <= (wday_o >= WDAY_MAX) ? 3'd0 : wday_o + 3'd1;
    else if (dec_i)     wday_o <= (wday_o == 3'd0) ? WDAY_MAX : wday_o - 3'd1;
  end
endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
  import rtc_pkg::*;
#(
  parameter logic [WORD_W-1:0] UNLOCK_KEY = 32'hA5EB1357
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [WORD_W-1:0] time_o,
  output logic [WORD_W-1:0] date_o,
  output logic [2:0]        weekday_o,
  output logic              leap_o
);
  logic active, fmt24, dst_rec;
  logic wr_ok, ld_time, ld_date, wr_wday, ld_wday, wr_fmt, wr_dst;
  logic dst_add, dst_sub, tick_eff, day_inc, day_dec;
  logic [5:0] sec, min;
  logic [4:0] hr, day;
  logic [3:0] mon;
  logic [6:0] yr;
  logic [4:0] ld_hr, h12_in, h12_out;
  logic [7:0] hr_byte;

  rtc_unlock #(.KEY(UNLOCK_KEY)) i_unlock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .key_wr_i (wr_en_i && wr_addr_i == REG_KEY),
    .key_i    (wr_data_i),
    .active_o (active)
  );

  assign wr_ok    = wr_en_i & active;
  assign ld_time  = wr_ok & (wr_addr_i == REG_TIME);
  assign ld_date  = wr_ok & (wr_addr_i == REG_DATE);
  assign wr_wday  = wr_ok & (wr_addr_i == REG_WDAY);
  assign ld_wday  = wr_wday & (wr_data_i[2:0] != 3'd7);
  assign wr_fmt   = wr_ok & (wr_addr_i == REG_FMT);
  assign wr_dst   = wr_ok & (wr_addr_i == REG_DST);
  assign dst_add  = wr_dst & wr_data_i[0] & ~wr_data_i[1];
  assign dst_sub  = wr_dst & wr_data_i[1] & ~wr_data_i[0];
  // any register write that moves time or date swallows the second pulse
  assign tick_eff = sec_tick_i & active & ~(ld_time | ld_date | wr_wday | wr_dst);

  // hour decode from the written word, scale chosen by current format
  assign h12_in = (wr_data_i[20] ? 5'd10 : 5'd0) + {1'b0, wr_data_i[19:16]};
  assign ld_hr  = fmt24
                ? 5'(bcd2bin({2'b0, wr_data_i[21:16]}))
                : ((h12_in == 5'd12) ? 5'd0 : h12_in) + (wr_data_i[21] ? 5'd12 : 5'd0);

  rtc_time_core i_time (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (~active),
    .ld_i      (ld_time),
    .ld_sec_i  (6'(bcd2bin({1'b0, wr_data_i[6:0]}))),
    .ld_min_i  (6'(bcd2bin({1'b0, wr_data_i[14:8]}))),
    .ld_hr_i   (ld_hr),
    .tick_i    (tick_eff),
    .add_i     (dst_add),
    .sub_i     (dst_sub),
    .sec_o     (sec),
    .min_o     (min),
    .hr_o      (hr),
    .day_inc_o (day_inc),
    .day_dec_o (day_dec)
  );

  rtc_calendar i_cal (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (~active),
    .ld_date_i (ld_date),
    .ld_day_i  (5'(bcd2bin({2'b0, wr_data_i[5:0]}))),
    .ld_mon_i  (4'(bcd2bin({3'b0, wr_data_i[12:8]}))),
    .ld_yr_i   (bcd2bin(wr_data_i[23:16])),
    .ld_wday_i (ld_wday),
    .ld_wval_i (wr_data_i[2:0]),
    .inc_i     (day_inc),
    .dec_i     (day_dec),
    .day_o     (day),
    .mon_o     (mon),
    .yr_o      (yr),
    .wday_o    (weekday_o),
    .leap_o    (leap_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fmt24 <= 1'b1;
    else if (!active) fmt24 <= 1'b1;
    else if (wr_fmt) fmt24 <= wr_data_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dst_rec <= 1'b0;
    else if (!active)  dst_rec <= 1'b0;
    else if (dst_add)  dst_rec <= 1'b1;
    else if (dst_sub)  dst_rec <= 1'b0;
    else if (wr_dst && !wr_data_i[0] && !wr_data_i[1]) dst_rec <= wr_data_i[2];
  end

  // hour presentation: BCD 00-23, or {PM, tens, units} with 12,1..11
  assign h12_out = (hr == 5'd0) ? 5'd12 : ((hr > 5'd12) ? hr - 5'd12 : hr);
  assign hr_byte = fmt24
                 ? bin2bcd({2'b0, hr})
                 : {2'b0, hr >= 5'd12, h12_out >= 5'd10,
                    4'((h12_out >= 5'd10) ? h12_out - 5'd10 : h12_out)};

  assign time_o = {8'b0, hr_byte, bin2bcd({1'b0, min}), bin2bcd({1'b0, sec})};
  assign date_o = {8'b0, bin2bcd(yr), bin2bcd({3'b0, mon}), bin2bcd({2'b0, day})};

  always_comb begin
    case (rd_addr_i)
      REG_KEY:  rd_data_o = {31'b0, active};
      REG_TIME: rd_data_o = time_o;
      REG_DATE: rd_data_o = date_o;
      REG_WDAY: rd_data_o = {29'b0, weekday_o};
      REG_FMT:  rd_data_o = {31'b0, fmt24};
      REG_LEAP: rd_data_o = {31'b0, leap_o};
      REG_DST:  rd_data_o = {29'b0, dst_rec, 2'b0};
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_clock_chk.sv
module rtc_bcd_clock_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        active,
  input logic        fmt24,
  input logic        tick_eff,
  input logic        ld_time,
  input logic        dst_add,
  input logic        dst_sub,
  input logic        dst_rec,
  input logic [31:0] time_o,
  input logic [31:0] date_o,
  input logic [2:0]  weekday_o,
  input logic        leap_o
);
  AST_LOCKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (time_o == 32'h0 && date_o == 32'h00000101 && weekday_o == 3'd6)); // R1
  AST_ACTIVE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |=> active); // R2
  AST_SEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_eff && time_o[3:0] < 4'd9) |=> time_o[3:0] == $past(time_o[3:0]) + 4'd1); // R3
  AST_LEAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leap_o == (2'(date_o[17:16] + {date_o[20], 1'b0}) == 2'd0)); // R5
  AST_PM_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fmt24 && tick_eff && time_o[21:0] == 22'h115959) |=> time_o[21:16] == 6'h32); // R6
  AST_WDAY_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    weekday_o != 3'd7); // R7
  AST_DST_ADD_REC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_add |=> dst_rec); // R8
  AST_DST_SUB_REC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_sub |=> !dst_rec); // R9
  AST_WRITE_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_time |=> $stable(date_o)); // R10
endmodule

bind rtc_bcd_clock rtc_bcd_clock_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .active    (active),
  .fmt24     (fmt24),
  .tick_eff  (tick_eff),
  .ld_time   (ld_time),
  .dst_add   (dst_add),
  .dst_sub   (dst_sub),
  .dst_rec   (dst_rec),
  .time_o    (time_o),
  .date_o    (date_o),
  .weekday_o (weekday_o),
  .leap_o    (leap_o)
);

// File: tb/test_rtc_bcd_clock.sv
module test_rtc_bcd_clock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data, time_w, date_w;
  logic [2:0]  wday;
  logic        leap;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  localparam logic [2:0] A_KEY = 3'd0, A_TIME = 3'd1, A_DATE = 3'd2, A_WDAY = 3'd3,
                         A_FMT = 3'd4, A_LEAP = 3'd5, A_DST = 3'd6;

  always #4 clk = ~clk;

  rtc_bcd_clock i_rtc_bcd_clock (
    .clk_i(clk), .rst_ni(rst_n), .sec_tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .time_o(time_w), .date_o(date_w),
    .weekday_o(wday), .leap_o(leap)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_tick(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic sec_pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic set_all(input logic [31:0] t, input logic [31:0] d, input logic [2:0] w);
    wr(A_TIME, t); wr(A_DATE, d); wr(A_WDAY, {29'b0, w});
  endtask

  task automatic t_locked();
    logic [31:0] r;
    rd(A_KEY, r);  check("R1 status after reset", r, 32'h0);
    check("R1 reset time", time_w, 32'h0);
    check("R1 reset date", date_w, 32'h000101);
    check("R1 reset weekday", {29'b0, wday}, 32'd6);
    rd(A_FMT, r);  check("R1 reset format", r, 32'h1);
    check("R5 year 00 leap", {31'b0, leap}, 32'h1);
    sec_pulse();   check("R1 tick ignored while locked", time_w, 32'h0);
    wr(A_TIME, 32'h120000); check("R1 write ignored while locked", time_w, 32'h0);
    wr(A_KEY, 32'h12345678); rd(A_KEY, r); check("R2 wrong key", r, 32'h0);
  endtask

  task automatic t_unlock();
    logic [31:0] r;
    wr(A_KEY, 32'hA5EB1357); rd(A_KEY, r); check("R2 unlocked status", r, 32'h1);
    wr(A_KEY, 32'h0); rd(A_KEY, r); check("R2 status sticky", r, 32'h1);
    sec_pulse(); check("R2 counting after unlock", time_w, 32'h000001);
  endtask

  task automatic t_roll24();
    set_all(32'h235958, 32'h231231, 3'd0);
    sec_pulse(); check("R3 seconds step", time_w, 32'h235959);
    sec_pulse(); check("R3 midnight rollover", time_w, 32'h000000);
    check("R4 year rollover date", date_w, 32'h240101);
    check("R7 weekday step", {29'b0, wday}, 32'd1);
    check("R5 year 24 leap", {31'b0, leap}, 32'h1);
    wr(A_TIME, 32'h005959); sec_pulse(); check("R3 hour carry", time_w, 32'h010000);
  endtask

  task automatic t_months();
    logic [31:0] r;
    set_all(32'h235959, 32'h230228, 3'd2);
    check("R5 year 23 not leap", {31'b0, leap}, 32'h0);
    sec_pulse(); check("R4 Feb 28 non-leap", date_w, 32'h230301);
    wr(A_DATE, 32'h240228); wr(A_TIME, 32'h235959);
    sec_pulse(); check("R5 Feb 29 leap", date_w, 32'h240229);
    wr(A_TIME, 32'h235959);
    sec_pulse(); check("R5 leap Feb end", date_w, 32'h240301);
    rd(A_LEAP, r); check("R5 leap register", r, 32'h1);
    wr(A_DATE, 32'h230430); wr(A_TIME, 32'h235959);
    sec_pulse(); check("R4 30-day month", date_w, 32'h230501);
    wr(A_DATE, 32'h991231); wr(A_TIME, 32'h235959);
    sec_pulse(); check("R4 year 99 wrap", date_w, 32'h000101);
  endtask

  task automatic t_12h();
    logic [31:0] r;
    wr(A_FMT, 32'h0);
    set_all(32'h115959, 32'h230115, 3'd2);
    sec_pulse(); check("R6 11 AM to 12 PM", time_w, 32'h320000);
    wr(A_TIME, 32'h325959);
    sec_pulse(); check("R6 12 PM to 1 PM", time_w, 32'h210000);
    wr(A_TIME, 32'h315959);
    sec_pulse(); check("R6 11 PM to 12 AM", time_w, 32'h120000);
    check("R6 date carry at 12 AM", date_w, 32'h230116);
    check("R7 weekday at 12 AM", {29'b0, wday}, 32'd3);
    wr(A_TIME, 32'h210000);
    wr(A_FMT, 32'h1); check("R6 format re-encode", time_w, 32'h130000);
    rd(A_FMT, r); check("R6 format readback", r, 32'h1);
  endtask

  task automatic t_wday();
    wr(A_WDAY, 32'd3); wr(A_WDAY, 32'd7);
    check("R7 reserved 7 ignored", {29'b0, wday}, 32'd3);
    wr(A_WDAY, 32'd6); wr(A_TIME, 32'h235959);
    sec_pulse(); check("R7 Saturday wraps", {29'b0, wday}, 32'd0);
  endtask

  task automatic t_dst();
    logic [31:0] r;
    set_all(32'h235930, 32'h231231, 3'd6);
    wr(A_DST, 32'h1);
    check("R8 add time", time_w, 32'h005930);
    check("R8 add date carry", date_w, 32'h240101);
    check("R8 add weekday", {29'b0, wday}, 32'd0);
    rd(A_DST, r); check("R8 record set, bits clear", r, 32'h4);
    wr(A_DST, 32'h2);
    check("R9 sub time", time_w, 32'h235930);
    check("R9 sub date borrow", date_w, 32'h231231);
    check("R9 sub weekday", {29'b0, wday}, 32'd6);
    rd(A_DST, r); check("R9 record cleared", r, 32'h0);
    set_all(32'h001000, 32'h240301, 3'd5);
    wr(A_DST, 32'h2);
    check("R9 leap Feb borrow", date_w, 32'h240229);
    check("R9 borrow hour", time_w, 32'h231000);
    set_all(32'h000000, 32'h000101, 3'd0);
    wr(A_DST, 32'h2); check("R9 year 00 borrow", date_w, 32'h991231);
    wr(A_DST, 32'h3); check("R9 both bits no change", time_w, 32'h230000);
    wr(A_DST, 32'h4); rd(A_DST, r); check("R9 record direct write", r, 32'h4);
  endtask

  task automatic t_prio();
    logic [31:0] r;
    wr(A_TIME, 32'h100000);
    wr_tick(A_TIME, 32'h120000); check("R10 time write beats tick", time_w, 32'h120000);
    wr(A_TIME, 32'h235959);
    wr_tick(A_DATE, 32'h230610);
    check("R10 date write beats tick", date_w, 32'h230610);
    check("R10 time held on date write", time_w, 32'h235959);
    rd(A_TIME, r); check("R11 time readback", r, 32'h235959);
    rd(A_DATE, r); check("R11 date readback", r, 32'h230610);
    rd(3'd7, r); check("R11 unused address", r, 32'h0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_locked();
    t_unlock();
    t_roll24();
    t_months();
    t_12h();
    t_wday();
    t_dst();
    t_prio();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule